// File: doc/BRIEF.md
# Multicycle Issue Interlock

This block decides, one instruction at a time, whether the decoded instruction in the issue stage may leave it or must be held. The pipeline it guards has four execution paths of unequal length: a one-cycle integer stage, a pipelined floating-point adder of `ADD_N` stages, a pipelined multiplier of `MUL_N` stages, and a divider that is not pipelined and stays busy for `DIV_LAT` cycles. After execution every instruction passes through one memory stage and then one write-back stage. The register file has a single write port.

The block keeps its own picture of what is in flight. It records the destination tag held in every execution stage, in the memory stage and in the write-back stage. It keeps a countdown for the divider and a shift register that marks the future cycles in which the write port is already claimed. Results are not forwarded, so a reader waits until the producing instruction has left write-back. The `stall` output is combinational from the issue-stage inputs and the tracked state. An instruction issues in any cycle in which `idValid` is high and `stall` is low.

Top module: `issue_interlock`

## Requirements
- R1: After reset nothing is in flight, so the first valid instruction of any unit class issues with `stall` low.
- R2: `stall` is low in every cycle in which `idValid` is low.
- R3: An instruction issued in cycle s with execute latency L is in flight until write-back in cycle s+L+2. L is 1 for unit code 0 (integer), `ADD_N` for code 1 (adder), `MUL_N` for code 2 (multiplier) and `DIV_LAT` for code 3 (divider). A reader of its result issues no earlier than cycle s+L+3.
- R4: A source whose enable is high stalls the instruction while any in-flight instruction that writes a register carries an equal tag. This covers the execute stages, the memory stage and the write-back stage.
- R5: A tag is `REG_W+1` bits wide. Bit `REG_W` selects the floating-point file (1) or the integer file (0), and the lower bits hold the register index. Two tags that differ only in that top bit never match.
- R6: A divide issued in cycle s holds any further divide in the issue stage until cycle s+`DIV_LAT`.
- R7: Every issued instruction claims the write port for its write-back cycle, whether or not it writes a register. An instruction whose write-back cycle is already claimed stalls.
- R8: An instruction whose destination enable is high stalls while an equal destination tag sits in an adder stage, a multiplier stage or the divider. Integer, memory and write-back stages are not checked for this.
- R9: A source or destination whose enable is low takes no part in any comparison, whatever its tag.
- R10: A stalled instruction is held and issues in the first cycle in which none of the R4, R6, R7 or R8 conditions remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| idValid | input | 1 | Issue stage holds an instruction |
| idUnit | input | 2 | Unit class: 0 integer, 1 adder, 2 multiplier, 3 divider |
| idSrc1En | input | 1 | First source operand is used |
| idSrc1 | input | REG_W+1 | First source tag |
| idSrc2En | input | 1 | Second source operand is used |
| idSrc2 | input | REG_W+1 | Second source tag |
| idDstEn | input | 1 | Instruction writes a register |
| idDst | input | REG_W+1 | Destination tag |
| stall | output | 1 | Hold the instruction in the issue stage |

## Verification
The bench builds the block with `REG_W` = 3 and `DIV_LAT` = 9, and keeps the default adder and multiplier depths of 4 and 7. Eight registers per file make tag collisions between random instructions frequent, so source and destination matches, and near misses that differ only in the file bit, occur throughout the random phase. A nine-cycle divide ends after the multiplier, which lets divide, multiply and add write-backs collide on the single port within a short run. Directed sequences pin the exact stall counts for a dependent add behind a multiply, for back-to-back divides, for a write-port collision and for a write-after-write case.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;

  // Strobes from issue control to the occupancy tracker, one per path.
  typedef struct packed {
    logic toInt;
    logic toAdd;
    logic toMul;
    logic toDiv;
  } issue_stb_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ilk_track.sv
module ilk_track
  import ilk_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int ADD_N   = 4,
  parameter int MUL_N   = 7,
  parameter int DIV_LAT = 24,
  localparam int TAG_W  = REG_W + 1,
  localparam int NSLOT  = 1 + ADD_N + MUL_N + 3,
  localparam int LMAX   = maxOf(maxOf(ADD_N, MUL_N), maxOf(DIV_LAT, 1)),
  localparam int RSV_W  = LMAX + 1,
  localparam int CNT_W  = $clog2(DIV_LAT + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  issue_stb_t             stb,
  input  logic                   dstEn,
  input  logic [TAG_W-1:0]       dst,
  output logic [NSLOT-1:0]       occVld,
  output logic [NSLOT*TAG_W-1:0] occTag,
  output logic [RSV_W-1:0]       resv,
  output logic                   divBusy,
  output logic [3:0]             exitVec
);

  localparam int ADD_BASE = 1;
  localparam int MUL_BASE = ADD_BASE + ADD_N;
  localparam int DIV_SLOT = MUL_BASE + MUL_N;
  localparam int MEM_SLOT = DIV_SLOT + 1;
  localparam int WB_SLOT  = MEM_SLOT + 1;

  logic             exV;
  logic [TAG_W-1:0] exT;
  logic [ADD_N-1:0] addV;
  logic [TAG_W-1:0] addT [ADD_N];
  logic [MUL_N-1:0] mulV;
  logic [TAG_W-1:0] mulT [MUL_N];
  logic [CNT_W-1:0] divCnt;
  logic             divV;
  logic [TAG_W-1:0] divT;
  logic             memV, wbV;
  logic [TAG_W-1:0] memT, wbT, memNext;
  logic [RSV_W-1:0] resvNext;

  // Integer stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exV <= 1'b0;
      exT <= '0;
    end else begin
      exV <= stb.toInt & dstEn;
      exT <= dst;
    end
  end

  // Adder and multiplier stage chains
  for (genvar g = 0; g < ADD_N; g++) begin : gAdd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addV[g] <= 1'b0;
        addT[g] <= '0;
      end else if (g == 0) begin
        addV[g] <= stb.toAdd & dstEn;
        addT[g] <= dst;
      end else begin
        addV[g] <= addV[(g == 0) ? 0 : g - 1];
        addT[g] <= addT[(g == 0) ? 0 : g - 1];
      end
    end
  end

  for (genvar g = 0; g < MUL_N; g++) begin : gMul
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mulV[g] <= 1'b0;
        mulT[g] <= '0;
      end else if (g == 0) begin
        mulV[g] <= stb.toMul & dstEn;
        mulT[g] <= dst;
      end else begin
        mulV[g] <= mulV[(g == 0) ? 0 : g - 1];
        mulT[g] <= mulT[(g == 0) ? 0 : g - 1];
      end
    end
  end

  // Divider: counter holds the cycles left in the unit, current one included
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      divV   <= 1'b0;
      divT   <= '0;
    end else if (stb.toDiv) begin
      divCnt <= CNT_W'(DIV_LAT);
      divV   <= dstEn;
      divT   <= dst;
    end else if (divCnt != '0) begin
      divCnt <= divCnt - 1'b1;
      if (divCnt == CNT_W'(1)) divV <= 1'b0;
    end
  end

  assign divBusy = (divCnt > CNT_W'(1));

  // Register-writing instructions leaving execution this cycle
  assign exitVec = {divV & (divCnt == CNT_W'(1)), mulV[MUL_N-1], addV[ADD_N-1], exV};

  always_comb begin
    memNext = '0;
    if (exitVec[0]) memNext = memNext | exT;
    if (exitVec[1]) memNext = memNext | addT[ADD_N-1];
    if (exitVec[2]) memNext = memNext | mulT[MUL_N-1];
    if (exitVec[3]) memNext = memNext | divT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memV <= 1'b0;
      memT <= '0;
      wbV  <= 1'b0;
      wbT  <= '0;
    end else begin
      memV <= |exitVec;
      memT <= memNext;
      wbV  <= memV;
      wbT  <= memT;
    end
  end

  // Write-port claims: bit j means the port is taken j+2 cycles from now
  always_comb begin
    resvNext = resv >> 1;
    if (stb.toInt) resvNext[0]         = 1'b1;
    if (stb.toAdd) resvNext[ADD_N-1]   = 1'b1;
    if (stb.toMul) resvNext[MUL_N-1]   = 1'b1;
    if (stb.toDiv) resvNext[DIV_LAT-1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resv <= '0;
    else       resv <= resvNext;
  end

  // Flattened occupancy view
  assign occVld[0]             = exV;
  assign occTag[0 +: TAG_W]    = exT;
  for (genvar g = 0; g < ADD_N; g++) begin : gOccAdd
    assign occVld[ADD_BASE + g]                 = addV[g];
    assign occTag[(ADD_BASE + g)*TAG_W +: TAG_W] = addT[g];
  end
  for (genvar g = 0; g < MUL_N; g++) begin : gOccMul
    assign occVld[MUL_BASE + g]                 = mulV[g];
    assign occTag[(MUL_BASE + g)*TAG_W +: TAG_W] = mulT[g];
  end
  assign occVld[DIV_SLOT]                 = divV;
  assign occTag[DIV_SLOT*TAG_W +: TAG_W]  = divT;
  assign occVld[MEM_SLOT]                 = memV;
  assign occTag[MEM_SLOT*TAG_W +: TAG_W]  = memT;
  assign occVld[WB_SLOT]                  = wbV;
  assign occTag[WB_SLOT*TAG_W +: TAG_W]   = wbT;

endmodule

// File: rtl/ilk_issue_ctrl.sv
module ilk_issue_ctrl
  import ilk_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int ADD_N   = 4,
  parameter int MUL_N   = 7,
  parameter int DIV_LAT = 24,
  localparam int TAG_W  = REG_W + 1,
  localparam int NSLOT  = 1 + ADD_N + MUL_N + 3,
  localparam int LMAX   = maxOf(maxOf(ADD_N, MUL_N), maxOf(DIV_LAT, 1)),
  localparam int RSV_W  = LMAX + 1
) (
  input  logic                   idValid,
  input  logic [1:0]             idUnit,
  input  logic                   idSrc1En,
  input  logic [TAG_W-1:0]       idSrc1,
  input  logic                   idSrc2En,
  input  logic [TAG_W-1:0]       idSrc2,
  input  logic                   idDstEn,
  input  logic [TAG_W-1:0]       idDst,
  input  logic [NSLOT-1:0]       occVld,
  input  logic [NSLOT*TAG_W-1:0] occTag,
  input  logic [RSV_W-1:0]       resv,
  input  logic                   divBusy,
  output logic                   stall,
  output issue_stb_t             stb
);

  // Slots that can finish after a later, shorter instruction
  localparam int WAW_LO = 1;
  localparam int WAW_HI = ADD_N + MUL_N + 1;

  unit_e            unit;
  logic             rawHit, wawHit, portHit, divHit, go;
  logic [TAG_W-1:0] slotTag;

  assign unit = unit_e'(idUnit);

  always_comb begin
    rawHit  = 1'b0;
    wawHit  = 1'b0;
    slotTag = '0;
    for (int i = 0; i < NSLOT; i++) begin
      slotTag = occTag[i*TAG_W +: TAG_W];
      if (occVld[i]) begin
        if (idSrc1En && (slotTag == idSrc1)) rawHit = 1'b1;
        if (idSrc2En && (slotTag == idSrc2)) rawHit = 1'b1;
        if (idDstEn && (i >= WAW_LO) && (i <= WAW_HI) && (slotTag == idDst)) wawHit = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (unit)
      UNIT_INT: portHit = resv[1];
      UNIT_ADD: portHit = resv[ADD_N];
      UNIT_MUL: portHit = resv[MUL_N];
      UNIT_DIV: portHit = resv[DIV_LAT];
      default:  portHit = 1'b0;
    endcase
  end

  assign divHit = (unit == UNIT_DIV) & divBusy;
  assign stall  = idValid & (rawHit | wawHit | portHit | divHit);
  assign go     = idValid & ~stall;

  assign stb.toInt = go & (unit == UNIT_INT);
  assign stb.toAdd = go & (unit == UNIT_ADD);
  assign stb.toMul = go & (unit == UNIT_MUL);
  assign stb.toDiv = go & (unit == UNIT_DIV);

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import ilk_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int ADD_N   = 4,
  parameter int MUL_N   = 7,
  parameter int DIV_LAT = 24,
  localparam int TAG_W  = REG_W + 1,
  localparam int NSLOT  = 1 + ADD_N + MUL_N + 3,
  localparam int LMAX   = maxOf(maxOf(ADD_N, MUL_N), maxOf(DIV_LAT, 1)),
  localparam int RSV_W  = LMAX + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idValid,
  input  logic [1:0]       idUnit,
  input  logic             idSrc1En,
  input  logic [TAG_W-1:0] idSrc1,
  input  logic             idSrc2En,
  input  logic [TAG_W-1:0] idSrc2,
  input  logic             idDstEn,
  input  logic [TAG_W-1:0] idDst,
  output logic             stall
);

  issue_stb_t             stb;
  logic [NSLOT-1:0]       occVld;
  logic [NSLOT*TAG_W-1:0] occTag;
  logic [RSV_W-1:0]       resv;
  logic                   divBusy;
  logic [3:0]             exitVec;

  ilk_issue_ctrl #(
    .REG_W(REG_W), .ADD_N(ADD_N), .MUL_N(MUL_N), .DIV_LAT(DIV_LAT)
  ) u_ctrl (
    .idValid (idValid),
    .idUnit  (idUnit),
    .idSrc1En(idSrc1En),
    .idSrc1  (idSrc1),
    .idSrc2En(idSrc2En),
    .idSrc2  (idSrc2),
    .idDstEn (idDstEn),
    .idDst   (idDst),
    .occVld  (occVld),
    .occTag  (occTag),
    .resv    (resv),
    .divBusy (divBusy),
    .stall   (stall),
    .stb     (stb)
  );

  ilk_track #(
    .REG_W(REG_W), .ADD_N(ADD_N), .MUL_N(MUL_N), .DIV_LAT(DIV_LAT)
  ) u_track (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .dstEn  (idDstEn),
    .dst    (idDst),
    .occVld (occVld),
    .occTag (occTag),
    .resv   (resv),
    .divBusy(divBusy),
    .exitVec(exitVec)
  );

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
  parameter int REG_W   = 5,
  parameter int DIV_LAT = 24,
  localparam int TAG_W  = REG_W + 1,
  localparam int CNT_W  = $clog2(DIV_LAT + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             idValid,
  input logic [1:0]       idUnit,
  input logic             idSrc1En,
  input logic [TAG_W-1:0] idSrc1,
  input logic             idDstEn,
  input logic [TAG_W-1:0] idDst,
  input logic             stall,
  input logic [3:0]       exitVec
);

  logic             goNow, divGo;
  logic [CNT_W-1:0] gapCnt;
  logic             lastWr, lastMulWr;
  logic [TAG_W-1:0] lastDst;

  assign goNow = idValid & ~stall;
  assign divGo = goNow & (idUnit == 2'd3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt    <= '0;
      lastWr    <= 1'b0;
      lastMulWr <= 1'b0;
      lastDst   <= '0;
    end else begin
      if (divGo)               gapCnt <= CNT_W'(DIV_LAT - 1);
      else if (gapCnt != '0)   gapCnt <= gapCnt - 1'b1;
      lastWr    <= goNow & idDstEn;
      lastMulWr <= goNow & idDstEn & (idUnit == 2'd2);
      lastDst   <= idDst;
    end
  end

  assert_idle_no_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    !idValid |-> !stall);

  assert_single_writer_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(exitVec));

  assert_div_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    divGo |-> (gapCnt == '0));

  assert_raw_next_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lastWr && idValid && idSrc1En && (idSrc1 == lastDst)) |-> stall);

  assert_waw_mul_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lastMulWr && idValid && idDstEn && (idDst == lastDst)) |-> stall);

endmodule

bind issue_interlock ilk_checker #(.REG_W(REG_W), .DIV_LAT(DIV_LAT)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .idValid (idValid),
  .idUnit  (idUnit),
  .idSrc1En(idSrc1En),
  .idSrc1  (idSrc1),
  .idDstEn (idDstEn),
  .idDst   (idDst),
  .stall   (stall),
  .exitVec (exitVec)
);

// File: tb/issue_interlock_tb.sv
`timescale 1ns/1ps
module issue_interlock_tb;

  localparam int REG_W   = 3;
  localparam int ADD_N   = 4;
  localparam int MUL_N   = 7;
  localparam int DIV_LAT = 9;
  localparam int TAG_W   = REG_W + 1;

  logic             clk = 1'b0;
  logic             rstN;
  logic             idValid;
  logic [1:0]       idUnit;
  logic             idSrc1En, idSrc2En, idDstEn;
  logic [TAG_W-1:0] idSrc1, idSrc2, idDst;
  logic             stall;

  always #2.5 clk = ~clk;

  issue_interlock #(.REG_W(REG_W), .ADD_N(ADD_N), .MUL_N(MUL_N), .DIV_LAT(DIV_LAT)) u_dut (
    .clk(clk), .rstN(rstN), .idValid(idValid), .idUnit(idUnit),
    .idSrc1En(idSrc1En), .idSrc1(idSrc1), .idSrc2En(idSrc2En), .idSrc2(idSrc2),
    .idDstEn(idDstEn), .idDst(idDst), .stall(stall)
  );

  typedef struct {
    int iss;
    int lat;
    int unit;
    int dst;
    bit dEn;
  } rec_t;

  rec_t flight[$];
  int   cyc = 0;
  int   nChk = 0;
  int   nFail = 0;
  bit   done = 0;

  function automatic int latOf(input int u);
    case (u)
      0: return 1;
      1: return ADD_N;
      2: return MUL_N;
      default: return DIV_LAT;
    endcase
  endfunction

  function automatic int tg(input bit fp, input int idx);
    return (int'(fp) << REG_W) | idx;
  endfunction

  // Reference decision from the requirements, over the list of issued work
  function automatic bit modelStall();
    int L;
    bit s;
    if (!idValid) return 1'b0;
    L = latOf(int'(idUnit));
    s = 1'b0;
    foreach (flight[i]) begin
      int wb;
      wb = flight[i].iss + flight[i].lat + 2;
      if (flight[i].dEn && cyc <= wb) begin
        if (idSrc1En && flight[i].dst == int'(idSrc1)) s = 1'b1;
        if (idSrc2En && flight[i].dst == int'(idSrc2)) s = 1'b1;
      end
      if (idDstEn && flight[i].dEn && flight[i].unit != 0 &&
          cyc <= flight[i].iss + flight[i].lat && flight[i].dst == int'(idDst)) s = 1'b1;
      if (wb == cyc + L + 2) s = 1'b1;
      if (idUnit == 2'd3 && flight[i].unit == 3 && cyc < flight[i].iss + DIV_LAT) s = 1'b1;
    end
    return s;
  endfunction

  // One cycle: inputs are already driven after a falling edge
  task automatic tick(input string req, output bit expS);
    rec_t r;
    #1;
    expS = modelStall();
    nChk++;
    if (stall !== expS) begin
      nFail++;
      $display("FAIL %s cycle %0d: stall=%b expected %b", req, cyc, stall, expS);
    end
    if (idValid && !expS) begin
      r.iss = cyc; r.lat = latOf(int'(idUnit)); r.unit = int'(idUnit);
      r.dst = int'(idDst); r.dEn = idDstEn;
      flight.push_back(r);
    end
    while (flight.size() > 0 && flight[0].iss + flight[0].lat + 2 < cyc - DIV_LAT - 4)
      void'(flight.pop_front());
    @(negedge clk);
    cyc++;
  endtask

  task automatic drive(input bit v, input int u, input bit e1, input int s1,
                       input bit e2, input int s2, input bit ed, input int d);
    idValid  = v;
    idUnit   = 2'(u);
    idSrc1En = e1; idSrc1 = TAG_W'(s1);
    idSrc2En = e2; idSrc2 = TAG_W'(s2);
    idDstEn  = ed; idDst  = TAG_W'(d);
  endtask

  task automatic issueWait(input int u, input bit e1, input int s1, input bit e2, input int s2,
                           input bit ed, input int d, input string req, output int stalls);
    bit st;
    drive(1'b1, u, e1, s1, e2, s2, ed, d);
    stalls = 0;
    do begin
      tick(req, st);
      if (st) stalls++;
    end while (st);
    idValid = 1'b0;
  endtask

  task automatic idle(input int n);
    bit st;
    idValid = 1'b0;
    for (int k = 0; k < n; k++) tick("R2", st);
  endtask

  task automatic expectCount(input string req, input int got, input int want);
    nChk++;
    if (got != want) begin
      nFail++;
      $display("FAIL %s stall cycles=%0d expected %0d", req, got, want);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    bit st;
    void'($urandom(32'h5eed));
    rstN = 1'b0;
    drive(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
    repeat (3) @(negedge clk);
    // R1: reset state, nothing stalls
    nChk++;
    if (stall !== 1'b0) begin nFail++; $display("FAIL R1 reset stall=%b expected 0", stall); end
    rstN = 1'b1;
    @(negedge clk);

    // R1: first instruction after reset issues at once
    issueWait(1, 1'b1, tg(1,1), 1'b1, tg(1,2), 1'b1, tg(1,3), "R1", n);
    expectCount("R1", n, 0);
    idle(20);

    // R3 R4: add reading a multiply result waits MUL_N+2 cycles
    issueWait(2, 1'b0, 0, 1'b0, 0, 1'b1, tg(1,1), "R3", n);
    issueWait(1, 1'b1, tg(1,1), 1'b0, 0, 1'b1, tg(1,4), "R4", n);
    expectCount("R3 R4", n, MUL_N + 2);
    idle(20);

    // R5: integer r2 does not block a read of fp f2
    issueWait(0, 1'b0, 0, 1'b0, 0, 1'b1, tg(0,2), "R5", n);
    issueWait(1, 1'b1, tg(1,2), 1'b0, 0, 1'b1, tg(1,5), "R5", n);
    expectCount("R5", n, 0);
    idle(20);

    // R6: second divide waits DIV_LAT-1 cycles
    issueWait(3, 1'b0, 0, 1'b0, 0, 1'b1, tg(1,3), "R6", n);
    issueWait(3, 1'b0, 0, 1'b0, 0, 1'b1, tg(1,4), "R6", n);
    expectCount("R6", n, DIV_LAT - 1);
    idle(25);

    // R7: add entering three cycles after a multiply shares its write-back cycle
    issueWait(2, 1'b0, 0, 1'b0, 0, 1'b1, tg(1,5), "R7", n);
    idle(2);
    issueWait(1, 1'b0, 0, 1'b0, 0, 1'b1, tg(1,6), "R7", n);
    expectCount("R7", n, 1);
    idle(20);

    // R8: integer write to a register a multiply is still producing
    issueWait(2, 1'b0, 0, 1'b0, 0, 1'b1, tg(1,7), "R8", n);
    issueWait(0, 1'b0, 0, 1'b0, 0, 1'b1, tg(1,7), "R8", n);
    expectCount("R8", n, MUL_N);
    idle(20);

    // R9: disabled fields with matching tags are ignored
    issueWait(2, 1'b0, 0, 1'b0, 0, 1'b1, tg(1,0), "R9", n);
    issueWait(0, 1'b0, tg(1,0), 1'b1, tg(0,0), 1'b0, tg(1,0), "R9", n);
    expectCount("R9", n, 0);
    idle(20);

    // R2: no instruction, pending hazard on its tags, stall stays low
    issueWait(2, 1'b0, 0, 1'b0, 0, 1'b1, tg(1,1), "R2", n);
    drive(1'b0, 1, 1'b1, tg(1,1), 1'b0, 0, 1'b1, tg(1,1));
    for (int k = 0; k < 4; k++) tick("R2", st);
    idle(20);

    // R10 with R4 R6 R7 R8 mixed: random instruction stream against the model
    for (int k = 0; k < 2500; k++) begin
      int u;
      u = int'($urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0) idle(1);
      issueWait(u,
                1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 15)),
                "R10", n);
    end
    idle(20);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule